// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Controller

This block lets a synchronous host issue word or single-byte reads and writes to an external asynchronous 256K x 16 nonvolatile memory. The host presents an 18-bit word address, 16 bits of write data, a read/write flag and a two-bit lane mask together with a valid strobe. The block accepts the request while it is idle. It runs one bus cycle, then returns a single-cycle response that carries read data and an error flag.

On the memory side the block drives active-low chip select, write strobe, read strobe and one active-low select per byte lane. It also drives the word address, and a 16-bit data bus split into an output value, an output-enable and an input value. Each lane select follows the host mask. The access time is rounded up to whole clocks from two parameters, the clock period and the access time.

A power-good input from a supply monitor gates writes. While it is low, and for a hold-off of at least 1 µs after it returns, every write is refused with an error and the write strobe is never pulsed. Reads are not affected. If power drops during a write, the strobe is released at once and the write reports an error.

Top module: `async_mem_ctrl`

## Requirements
- R1: While reset is held and right after it is released, chip select, write strobe, read strobe and both lane selects are high, the data output-enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read has one setup cycle, then the read strobe is low for exactly N cycles, then one hold cycle. The setup cycle has chip select low and the read strobe high. N = ceil(ACCESS_PS / CLK_PS), which is 2 at the defaults. The write strobe stays high for the whole read. `rsp_valid` is high for the single cycle after the (N+2)th clock edge following the edge that accepted the request.
- R3: Mask bit 0 selects the lower lane, DQ[7:0], via `mem_lb_n`. Mask bit 1 selects the upper lane, DQ[15:8], via `mem_ub_n`. Both selects are active low and held for as long as chip select is low. Read data in a selected lane is the bus value sampled on the last read-strobe edge. Read data in an unselected lane returns as zero.
- R4: A write has the same shape and response timing as a read. The write strobe is low for exactly N cycles and the read strobe stays high. The data bus is driven from the setup cycle through the hold cycle. Only the bytes of the selected lanes change in memory.
- R5: The data output-enable is never high while the read strobe is low. It is low in the cycle before the read strobe falls.
- R6: A request with mask 00 gets `rsp_valid` in the cycle after the accepting edge, with error 0 and data 0, and chip select never falls.
- R7: A write is refused while `pwr_good` is low. It is also refused if it is accepted on any of the first H clock edges that sample `pwr_good` high after reset or after a low period. H = ceil(HOLDOFF_PS / CLK_PS), which is 50 at the defaults. A refused write responds in the cycle after acceptance with error 1, and no chip select or write strobe pulse. From edge H+1 onward, writes run normally.
- R8: Reads run with normal timing and data while the write lockout is active.
- R9: If `pwr_good` falls while the write strobe is low, the strobe rises in that same cycle. The write then completes with error 1.
- R10: Whenever chip select is high, the write strobe, read strobe and both lane selects are high and the data output-enable is low.
- R11: The memory address stays stable for the whole time chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply monitor: high when the supply is good |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 16 | Read data, with unselected lanes zero |
| rsp_err | output | 1 | Write refused or aborted by power loss |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_addr | output | 18 | Memory word address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Output-enable for the data bus |
| mem_dq_in | input | 16 | Data read from the memory bus |

## Verification
The assertions check the following on every cycle: bus contention and the turnaround before the read strobe falls, silence while deselected, at least one lane selected while chip select is low, a stable address, and no write strobe while the lockout is active. They also check the no-op response timing and that the lockout tracks `pwr_good`. Only the bench scenarios can show the memory contents. Those scenarios sweep addresses with every mask and compare against a shadow copy, and they confirm that unselected lanes read back as zero. They also check the exact strobe widths and response latency, the edge-exact end of the hold-off, and the abort of a write when power drops.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  // whole clocks needed to cover a time span, rounded up, never below one
  function automatic int unsigned span_to_cycles(int unsigned span_ps, int unsigned clk_ps);
    int unsigned c;
    c = (span_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/amc_wr_lockout.sv
module amc_wr_lockout #(
  parameter int unsigned HOLD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic locked
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 2);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              hold_cnt <= LOAD;
    else if (!pwr_good)      hold_cnt <= LOAD;
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign locked = !pwr_good || (hold_cnt != '0);

  assert_lock_when_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> locked);
  assert_lock_on_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> locked);

endmodule

// File: rtl/amc_lane_map.sv
module amc_lane_map #(
  parameter int unsigned LANES = 2
) (
  input  logic               active,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*8-1:0] bus_in,
  output logic [LANES-1:0]   sel_n,
  output logic [LANES*8-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g]        = !(active && mask[g]);
    assign merged[g*8 +: 8] = mask[g] ? bus_in[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/amc_sequencer.sv
module amc_sequencer
  import amc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned LANES   = 2,
  parameter int unsigned ACC_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 locked,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LANES*8-1:0]   req_wdata,
  input  logic [LANES-1:0]     req_mask,
  output logic                 rsp_valid,
  output logic [LANES*8-1:0]   rsp_rdata,
  output logic                 rsp_err,
  output logic                 bus_active,
  output logic [LANES-1:0]     op_mask_o,
  input  logic [LANES*8-1:0]   merged_in,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LANES*8-1:0]   mem_dq_out,
  output logic                 mem_dq_oe
);
  localparam int unsigned DW    = LANES * 8;
  localparam int unsigned CNT_W = $clog2(ACC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_CYC - 1);

  seq_state_t        state;
  logic              op_write;
  logic [LANES-1:0]  op_mask;
  logic [ADDR_W-1:0] op_addr;
  logic [DW-1:0]     op_wdata;
  logic [CNT_W-1:0]  acc_cnt;
  logic              abort_q;

  // named events for the checks
  logic evt_accept, evt_noop, evt_refuse, evt_launch, access_last, evt_done;

  assign req_ready   = (state == ST_IDLE);
  assign evt_accept  = req_valid && req_ready;
  assign evt_noop    = evt_accept && (req_mask == '0);
  assign evt_refuse  = evt_accept && !evt_noop && req_write && locked;
  assign evt_launch  = evt_accept && !evt_noop && !evt_refuse;
  assign access_last = (state == ST_ACCESS) && (acc_cnt == '0);
  assign evt_done    = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_write  <= 1'b0;
      op_mask   <= '0;
      op_addr   <= '0;
      op_wdata  <= '0;
      acc_cnt   <= '0;
      abort_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (evt_noop || evt_refuse) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
            rsp_err   <= evt_refuse;
          end else if (evt_launch) begin
            op_write <= req_write;
            op_mask  <= req_mask;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            abort_q  <= 1'b0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          acc_cnt <= CNT_LAST;
          state   <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (op_write && locked) abort_q <= 1'b1;
          if (acc_cnt == '0) begin
            rsp_rdata <= op_write ? '0 : merged_in;
            state     <= ST_HOLD;
          end else begin
            acc_cnt <= acc_cnt - 1'b1;
          end
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_err   <= abort_q;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  assign bus_active = (state != ST_IDLE);
  assign op_mask_o  = op_mask;
  assign mem_oe_n   = !((state == ST_ACCESS) && !op_write);
  assign mem_we_n   = !((state == ST_ACCESS) && op_write && !locked);
  assign mem_dq_oe  = bus_active && op_write;
  assign mem_addr   = op_addr;
  assign mem_dq_out = op_wdata;

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  assert_we_permit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !locked);
  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  assert_noop_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_noop |=> rsp_valid && !bus_active && !rsp_err);
  assert_refuse_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_refuse |=> rsp_valid && rsp_err && !bus_active);
  assert_done_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> rsp_valid && req_ready);
  assert_capture_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    access_last |=> (state == ST_HOLD));

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned CLK_PS     = 20000,
  parameter int unsigned ACCESS_PS  = 25000,
  parameter int unsigned HOLDOFF_PS = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int unsigned LANES    = 2;
  localparam int unsigned ACC_CYC  = span_to_cycles(ACCESS_PS, CLK_PS);
  localparam int unsigned HOLD_CYC = span_to_cycles(HOLDOFF_PS, CLK_PS);

  logic             locked;
  logic             bus_active;
  logic [LANES-1:0] op_mask;
  logic [LANES-1:0] sel_n;
  logic [15:0]      merged;

  amc_wr_lockout #(.HOLD_CYC(HOLD_CYC)) u_lockout (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .locked(locked)
  );

  amc_lane_map #(.LANES(LANES)) u_lanes (
    .active(bus_active), .mask(op_mask), .bus_in(mem_dq_in),
    .sel_n(sel_n), .merged(merged)
  );

  amc_sequencer #(.ADDR_W(ADDR_W), .LANES(LANES), .ACC_CYC(ACC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .locked(locked),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_active(bus_active), .op_mask_o(op_mask), .merged_in(merged),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  assign mem_ce_n = !bus_active;
  assign mem_lb_n = sel_n[0];
  assign mem_ub_n = sel_n[1];

  assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));
  assert_lane_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_lb_n && mem_ub_n));
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_lanes_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_lb_n) && $stable(mem_ub_n)));

endmodule

// File: tb/async_mem_ctrl_tb.sv
`timescale 1ns/1ps
module async_mem_ctrl_tb;
  localparam int CLK_PS = 20000, ACCESS_PS = 25000, HOLDOFF_PS = 1000000;
  localparam int N = (ACCESS_PS - 1) / CLK_PS + 1;
  localparam int H = (HOLDOFF_PS - 1) / CLK_PS + 1;

  logic clk = 0, rst_n = 0, pwr_good = 1;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  int checks = 0, errors = 0, cycles = 0;
  int oe_cnt, we_cnt; bit ce_seen;
  logic [15:0] model [int];
  logic [15:0] shadow [int];

  always #10 clk = ~clk;

  async_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [15:0] rd_model(logic [17:0] a);
    return model.exists(int'(a)) ? model[int'(a)] : 16'h0000;
  endfunction

  // memory model: unselected lanes carry junk so masking is visible
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_ub_n ? 8'hA5 : rd_model(mem_addr)[15:8],
                   mem_lb_n ? 8'h5A : rd_model(mem_addr)[7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (mem_ce_n === 1'b0 && mem_we_n === 1'b0 && mem_dq_oe === 1'b1) begin
      logic [15:0] w;
      w = rd_model(mem_addr);
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      model[int'(mem_addr)] = w;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle bus monitor, sampled mid-cycle
  logic [17:0] last_addr; bit last_ce;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n) oe_cnt++;
      if (!mem_we_n) we_cnt++;
      if (!mem_ce_n) ce_seen = 1;
      if (mem_dq_oe && !mem_oe_n) check(0, "R5 contention", 1, 0);
      if (mem_ce_n && !(mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe))
        check(0, "R10 deselect", {mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 5'b11110);
      if (!mem_ce_n && last_ce && mem_addr != last_addr) check(0, "R11 addr", mem_addr, last_addr);
      if (!pwr_good && !mem_we_n) check(0, "R9 strobe with power low", 0, 1);
      last_ce = !mem_ce_n; last_addr = mem_addr;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, output logic [15:0] rd, output bit er, output int lat);
    @(negedge clk);
    oe_cnt = 0; we_cnt = 0; ce_seen = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rsp_valid && lat < 1000) begin @(negedge clk); lat++; end
    rd = rsp_rdata; er = rsp_err;
  endtask

  function automatic logic [15:0] lanes(logic [15:0] v, logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic wr_chk(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] rd; bit er; int lat; logic [15:0] s;
    do_op(1, a, d, m, rd, er, lat);
    check(!er, "R4 write err", er, 0);
    check(lat == N + 2, "R4 latency", lat, N + 2);
    check(we_cnt == N && oe_cnt == 0, "R4 strobe width", we_cnt, N);
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    if (m[0]) s[7:0] = d[7:0];
    if (m[1]) s[15:8] = d[15:8];
    shadow[int'(a)] = s;
  endtask

  task automatic rd_chk(input logic [17:0] a, input logic [1:0] m, input string tag);
    logic [15:0] rd; bit er; int lat; logic [15:0] s;
    do_op(0, a, 16'h0, m, rd, er, lat);
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    check(rd == lanes(s, m), {tag, " R3 read data"}, rd, lanes(s, m));
    check(lat == N + 2 && oe_cnt == N && we_cnt == 0 && !er, {tag, " R2 read shape"}, lat, N + 2);
  endtask

  task automatic recover_then_write(input int k, input bit exp_err);
    logic [15:0] rd; bit er; int lat;
    @(negedge clk); pwr_good = 0;
    repeat (3) @(negedge clk);
    pwr_good = 1;
    repeat (k - 1) @(posedge clk);
    do_op(1, 18'h00100, 16'hBEEF, 2'b11, rd, er, lat);
    check(er == exp_err, "R7 hold-off boundary err", er, exp_err);
    check(exp_err ? (lat == 0 && !ce_seen && we_cnt == 0) : (lat == N + 2 && we_cnt == N),
          "R7 hold-off boundary bus", we_cnt, exp_err ? 0 : N);
    if (!exp_err) shadow[32'h100] = 16'hBEEF;
  endtask

  initial begin
    logic [15:0] rd; bit er; int lat;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
          "R1 in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && mem_ce_n, "R1 after reset", req_ready, 1);

    // lockout after power-up: write refused, read still works (R7, R8)
    do_op(1, 18'h00042, 16'h1234, 2'b11, rd, er, lat);
    check(er && lat == 0 && !ce_seen && we_cnt == 0, "R7 refused after reset", er, 1);
    do_op(0, 18'h00042, 16'h0, 2'b11, rd, er, lat);
    check(!er && rd == 16'h0000 && lat == N + 2 && oe_cnt == N, "R8 read in lockout", rd, 0);
    repeat (H + 10) @(negedge clk);

    // mask 00 no-op for read and write (R6)
    do_op(1, 18'h00042, 16'hFFFF, 2'b00, rd, er, lat);
    check(lat == 0 && !er && rd == 0 && !ce_seen, "R6 no-op write", lat, 0);
    do_op(0, 18'h00042, 16'h0, 2'b00, rd, er, lat);
    check(lat == 0 && !er && rd == 0 && !ce_seen, "R6 no-op read", lat, 0);
    rd_chk(18'h00042, 2'b11, "R6 memory untouched");

    // address sweep with every lane mask (R2, R3, R4)
    for (int i = 0; i < 12; i++) begin
      logic [17:0] a;
      logic [15:0] p;
      a = (i == 0) ? 18'h0 : (i == 11) ? 18'h3FFFF : 18'((i * 40503 + 17) & 32'h3FFFF);
      p = 16'(a) ^ 16'h5AC3;
      wr_chk(a, p, 2'b11);
      rd_chk(a, 2'b11, "word");
      wr_chk(a, ~p, 2'b01);
      rd_chk(a, 2'b01, "lower");
      rd_chk(a, 2'b10, "upper");
      wr_chk(a, {p[7:0], 8'h3C}, 2'b10);
      rd_chk(a, 2'b11, "merged");
    end

    // exact end of hold-off (R7)
    recover_then_write(H, 1'b1);
    recover_then_write(H + 1, 1'b0);
    rd_chk(18'h00100, 2'b11, "R7 after hold-off");

    // power drop in the middle of a write (R9)
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'h00200; req_wdata = 16'h7777; req_mask = 2'b11;
    @(posedge clk); @(negedge clk); req_valid = 0;
    @(posedge clk); @(negedge clk);
    check(!mem_we_n, "R9 strobe low before drop", mem_we_n, 0);
    pwr_good = 0;
    #1 check(mem_we_n, "R9 strobe released same cycle", mem_we_n, 1);
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    check(rsp_valid && rsp_err, "R9 aborted write err", rsp_err, 1);
    pwr_good = 1;
    repeat (H + 5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule